// File: doc/BRIEF.md
# I2C Display Command Slave

This block is the host-facing front end of a small segment-LCD driver. It sits on a two-wire I2C bus as a slave with a fixed 7-bit address. The bus lines are oversampled by the system clock, so SCL and SDA are ordinary inputs. The open-drain data pad is modelled as `sda_in` plus the pull-down enable `sda_oe`. The block holds a 22-byte display memory, which the scan logic reads through a separate combinational port. It also holds three configuration registers: drive mode, blink rate and LCD voltage adjust. Their decoded fields appear as static outputs.

After the address, the first byte of a write transfer is sorted by its upper bits. If it is a pointer, it loads the display-memory pointer, and the bytes that follow fill successive memory locations. If it is a command, it updates one configuration register, and the rest of that transfer is discarded. To read, the master sets the pointer, issues a repeated START with the read address, and clocks bytes out until it answers NACK. The pointer moves by one only when an acknowledge clock completes, and it wraps after the last location.

Top module: `lcd_i2c_cmd_slave`

## Requirements
- R1: Only address bytes whose upper seven bits are 0111111 are acknowledged. Bit 0 of the address byte selects the direction (0 = write, 1 = read), so 7Eh writes and 7Fh reads. Any other address leaves SDA released for the rest of the transfer.
- R2: After a matched address, the slave drives SDA low during the ninth clock of every byte it receives. Bytes travel MSB first.
- R3: If the first byte after a write address has bits 7:5 = 000 and a value from 00h to 15h, that value becomes the pointer. Each later byte of the same transfer is stored at the pointer. The stored byte can be read on `disp_data` when `disp_addr` selects that location.
- R4: The pointer advances by one only when an acknowledge clock completes: the slave's own ACK clock after a stored byte, or the master's ACK after a read byte. It wraps from 15h to 00h. A NACK from the master does not advance it.
- R5: In a read transfer, the byte at the pointer is shifted out MSB first. SDA is released during the master's acknowledge slot. After a NACK the slave drives nothing until the next START.
- R6: A first byte of the form 100 f s e 0 m (bit 4 = f, bit 3 = s, bit 2 = e, bit 0 = m, bit 1 = 0) sets `frame_fast`=f, `osc_on`=s, `disp_on`=s AND e, and `bias_half`=m.
- R7: A first byte of the form 110000 b1 b0 sets `blink_sel` to bits 1:0.
- R8: A first byte of the form 01 d v c3..c0 sets `seg_on_shared`=d (bit 5), `vadj_en`=v (bit 4) and `vadj_code`=bits 3:0. `follower_en` is low when `vadj_code` is 0000 or when d,v = 1,0, and high otherwise.
- R9: A first byte that matches none of the patterns in R3, R6, R7 and R8 changes nothing. This includes 000xxxxx with a value above 15h.
- R10: After a first byte handled as a command (R6 to R9), every further byte of the same transfer is acknowledged but changes neither the memory, the pointer nor any configuration output.
- R11: After reset, `frame_fast`, `osc_on`, `disp_on`, `bias_half` and `blink_sel` are 0. `seg_on_shared`=1, `vadj_en`=1, `vadj_code`=0000, `follower_en`=0, the pointer is 00h, and `sda_oe` is low.
- R12: A pulse on SCL or SDA shorter than the filter length (3 system clocks) is ignored. START and STOP are recognised only while the filtered SCL is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the data line low |
| disp_addr | input | 5 | Display memory location for the scan port |
| disp_data | output | 8 | Byte stored at `disp_addr` (0 if out of range) |
| bias_half | output | 1 | 1 = half bias, 0 = third bias |
| frame_fast | output | 1 | 1 = fast frame rate, 0 = slow |
| osc_on | output | 1 | Internal oscillator enable |
| disp_on | output | 1 | Display enable |
| blink_sel | output | 2 | Blink rate selection, 0 = off |
| seg_on_shared | output | 1 | Shared pin works as a segment output |
| vadj_en | output | 1 | Internal voltage adjustment enable |
| vadj_code | output | 4 | Voltage adjustment step |
| follower_en | output | 1 | Voltage follower enable |

## Verification
A wrong byte or bit counter shows up within one byte time. It moves the acknowledge slot, so the ACK the bench samples on the ninth clock disappears, or a read byte comes back shifted. A corrupted pointer stays hidden until data moves. It then shows up as a memory byte landing at the wrong `disp_addr`, or as the wrong first byte of the next read. This is why the wrap and NACK cases are read back through both ports. A wrong decode of the first byte shows up on the configuration outputs as soon as that byte completes. The sweep checks those outputs after every transfer.

// File: rtl/lcd_i2c_pkg.sv
package lcd_i2c_pkg;

  localparam int PTR_W = 5;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_ACK_OUT, ST_TX, ST_ACK_IN
  } bus_st_e;

  typedef enum logic [2:0] {
    K_PTR, K_MODE, K_BLINK, K_VADJ, K_NONE
  } byte_kind_e;

  // Sort the first byte of a write transfer.
  function automatic byte_kind_e classify(logic [7:0] b, logic [PTR_W-1:0] last);
    if (b[7:5] == 3'b000)
      return (b[PTR_W-1:0] <= last) ? K_PTR : K_NONE;
    else if (b[7:6] == 2'b01)
      return K_VADJ;
    else if (b[7:5] == 3'b100 && !b[1])
      return K_MODE;
    else if (b[7:2] == 6'b110000)
      return K_BLINK;
    else
      return K_NONE;
  endfunction

  function automatic logic [PTR_W-1:0] ptr_step(logic [PTR_W-1:0] p, logic [PTR_W-1:0] last);
    return (p == last) ? '0 : p + 1'b1;
  endfunction

  function automatic logic follower_on(logic de, logic ve, logic [3:0] da);
    return (da != 4'd0) && !(de && !ve);
  endfunction

endpackage

// File: rtl/lcd_i2c_line_filter.sv
module lcd_i2c_line_filter #(
  parameter int FILT_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic clean
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
      cnt_q  <= '0;
      clean  <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], raw};
      if (sync_q[1] == clean) begin
        cnt_q <= '0;
      end else if (cnt_q == CW'(FILT_LEN - 1)) begin
        cnt_q <= '0;
        clean <= sync_q[1];
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/lcd_i2c_bus_engine.sv
module lcd_i2c_bus_engine
  import lcd_i2c_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h3F
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_f,
  input  logic       sda_f,
  input  logic [7:0] rd_data,
  output logic       sda_oe,
  output logic       wr_stb,
  output logic       wr_first,
  output logic [7:0] wr_data,
  output logic       wr_acked,
  output logic       rd_acked,
  output logic       start_ev,
  output logic       stop_ev
);
  bus_st_e    st;
  logic [3:0] cnt;
  logic [7:0] sh;
  logic       scl_q, sda_q, is_addr, is_read, first;
  logic       scl_rise, scl_fall;

  assign scl_rise = scl_f & ~scl_q;
  assign scl_fall = ~scl_f & scl_q;
  assign start_ev = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_ev  = scl_f & scl_q & ~sda_q & sda_f;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_IDLE; cnt <= '0; sh <= '0;
      scl_q <= 1'b1; sda_q <= 1'b1;
      is_addr <= 1'b0; is_read <= 1'b0; first <= 1'b0;
      sda_oe <= 1'b0; wr_stb <= 1'b0; wr_first <= 1'b0; wr_data <= '0;
      wr_acked <= 1'b0; rd_acked <= 1'b0;
    end else begin
      scl_q <= scl_f; sda_q <= sda_f;
      wr_stb <= 1'b0; wr_acked <= 1'b0; rd_acked <= 1'b0;
      if (stop_ev) begin
        st <= ST_IDLE; sda_oe <= 1'b0;
      end else if (start_ev) begin
        st <= ST_RX; cnt <= '0; is_addr <= 1'b1; sda_oe <= 1'b0;
      end else begin
        case (st)
          ST_RX: begin
            if (scl_rise) begin
              sh  <= {sh[6:0], sda_f};
              cnt <= cnt + 1'b1;
            end else if (scl_fall && cnt == 4'd8) begin
              cnt <= '0;
              if (is_addr) begin
                if (sh[7:1] == DEV_ADDR) begin
                  st <= ST_ACK_OUT; sda_oe <= 1'b1;
                  is_read <= sh[0]; first <= 1'b1;
                end else begin
                  st <= ST_IDLE;
                end
              end else begin
                wr_stb <= 1'b1; wr_data <= sh; wr_first <= first;
                first <= 1'b0;
                st <= ST_ACK_OUT; sda_oe <= 1'b1;
              end
            end
          end
          ST_ACK_OUT: begin
            if (scl_fall) begin
              if (is_addr && is_read) begin
                st <= ST_TX; sh <= rd_data; sda_oe <= ~rd_data[7]; cnt <= '0;
              end else begin
                st <= ST_RX; sda_oe <= 1'b0; wr_acked <= ~is_addr;
              end
              is_addr <= 1'b0;
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (cnt == 4'd7) begin
                st <= ST_ACK_IN; sda_oe <= 1'b0;
              end else begin
                sh <= {sh[6:0], 1'b0}; sda_oe <= ~sh[6]; cnt <= cnt + 1'b1;
              end
            end
          end
          ST_ACK_IN: begin
            if (scl_rise) begin
              if (sda_f) st <= ST_IDLE;
              else       rd_acked <= 1'b1;
            end else if (scl_fall) begin
              st <= ST_TX; sh <= rd_data; sda_oe <= ~rd_data[7]; cnt <= '0;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/lcd_cmd_regs.sv
module lcd_cmd_regs
  import lcd_i2c_pkg::*;
#(
  parameter int RAM_DEPTH = 22
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_stb,
  input  logic             wr_first,
  input  logic [7:0]       wr_data,
  input  logic             wr_acked,
  input  logic             rd_acked,
  input  logic [PTR_W-1:0] disp_addr,
  output logic [7:0]       disp_data,
  output logic [7:0]       rd_data,
  output logic [PTR_W-1:0] ptr,
  output logic [3:0]       mode_q,
  output logic [1:0]       blink_q,
  output logic [5:0]       vadj_q
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(RAM_DEPTH - 1);

  logic [7:0] mem [RAM_DEPTH];
  logic       data_mode, pend_inc;
  byte_kind_e kind;

  assign kind      = classify(wr_data, LAST);
  assign rd_data   = mem[ptr];
  assign disp_data = (disp_addr <= LAST) ? mem[disp_addr] : 8'h00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < RAM_DEPTH; i++) mem[i] <= '0;
      ptr <= '0; data_mode <= 1'b0; pend_inc <= 1'b0;
      mode_q <= 4'b0000; blink_q <= 2'b00; vadj_q <= 6'b110000;
    end else begin
      if (wr_stb && wr_first) begin
        data_mode <= (kind == K_PTR);
        pend_inc  <= 1'b0;
        case (kind)
          K_PTR:   ptr     <= wr_data[PTR_W-1:0];
          K_MODE:  mode_q  <= {wr_data[4:2], wr_data[0]};
          K_BLINK: blink_q <= wr_data[1:0];
          K_VADJ:  vadj_q  <= wr_data[5:0];
          default: ;
        endcase
      end else if (wr_stb && data_mode) begin
        mem[ptr] <= wr_data;
        pend_inc <= 1'b1;
      end else if (wr_acked && pend_inc) begin
        ptr      <= ptr_step(ptr, LAST);
        pend_inc <= 1'b0;
      end else if (rd_acked) begin
        ptr <= ptr_step(ptr, LAST);
      end
    end
  end
endmodule

// File: rtl/lcd_i2c_cmd_slave.sv
module lcd_i2c_cmd_slave
  import lcd_i2c_pkg::*;
#(
  parameter int         RAM_DEPTH = 22,
  parameter int         FILT_LEN  = 3,
  parameter logic [6:0] DEV_ADDR  = 7'h3F
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       sda_oe,
  input  logic [4:0] disp_addr,
  output logic [7:0] disp_data,
  output logic       bias_half,
  output logic       frame_fast,
  output logic       osc_on,
  output logic       disp_on,
  output logic [1:0] blink_sel,
  output logic       seg_on_shared,
  output logic       vadj_en,
  output logic [3:0] vadj_code,
  output logic       follower_en
);
  logic [1:0]       raw_lines, clean_lines;
  logic [7:0]       rd_data, wr_data;
  logic             wr_stb, wr_first, wr_acked, rd_acked, start_ev, stop_ev;
  logic [PTR_W-1:0] ptr;
  logic [3:0]       mode_q;
  logic [1:0]       blink_q;
  logic [5:0]       vadj_q;

  assign raw_lines = {sda_in, scl_in};

  for (genvar g = 0; g < 2; g++) begin : g_line
    lcd_i2c_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk(clk), .rst_n(rst_n), .raw(raw_lines[g]), .clean(clean_lines[g])
    );
  end

  lcd_i2c_bus_engine #(.DEV_ADDR(DEV_ADDR)) u_eng (
    .clk(clk), .rst_n(rst_n), .scl_f(clean_lines[0]), .sda_f(clean_lines[1]),
    .rd_data(rd_data), .sda_oe(sda_oe), .wr_stb(wr_stb), .wr_first(wr_first),
    .wr_data(wr_data), .wr_acked(wr_acked), .rd_acked(rd_acked),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  lcd_cmd_regs #(.RAM_DEPTH(RAM_DEPTH)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_first(wr_first),
    .wr_data(wr_data), .wr_acked(wr_acked), .rd_acked(rd_acked),
    .disp_addr(disp_addr), .disp_data(disp_data), .rd_data(rd_data),
    .ptr(ptr), .mode_q(mode_q), .blink_q(blink_q), .vadj_q(vadj_q)
  );

  assign frame_fast    = mode_q[3];
  assign osc_on        = mode_q[2];
  assign disp_on       = mode_q[2] & mode_q[1];
  assign bias_half     = mode_q[0];
  assign blink_sel     = blink_q;
  assign seg_on_shared = vadj_q[5];
  assign vadj_en       = vadj_q[4];
  assign vadj_code     = vadj_q[3:0];
  assign follower_en   = follower_on(vadj_q[5], vadj_q[4], vadj_q[3:0]);
endmodule

// File: rtl/lcd_i2c_cmd_slave_chk.sv
module lcd_i2c_cmd_slave_chk #(
  parameter int RAM_DEPTH = 22
) (
  input logic        clk,
  input logic        rst_n,
  input logic        sda_oe,
  input logic        start_ev,
  input logic        stop_ev,
  input logic        wr_stb,
  input logic        wr_acked,
  input logic        rd_acked,
  input logic [4:0]  ptr,
  input logic [12:0] cfg,
  input logic [3:0]  vadj_code,
  input logic        follower_en
);
  a_r4_ptr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    ptr <= 5'(RAM_DEPTH - 1));

  a_r4_ptr_moves_on_event: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_stb || wr_acked || rd_acked) |=> $stable(ptr));

  a_r4_single_advance_source: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_acked && rd_acked));

  a_r5_release_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> !sda_oe);

  a_r12_release_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> !sda_oe);

  a_r9_cfg_only_on_byte: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> $stable(cfg));

  a_r8_follower_off_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (vadj_code == 4'd0) |-> !follower_en);
endmodule

bind lcd_i2c_cmd_slave lcd_i2c_cmd_slave_chk #(.RAM_DEPTH(RAM_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .start_ev(start_ev),
  .stop_ev(stop_ev), .wr_stb(wr_stb), .wr_acked(wr_acked), .rd_acked(rd_acked),
  .ptr(ptr),
  .cfg({frame_fast, osc_on, disp_on, bias_half, blink_sel, seg_on_shared,
        vadj_en, vadj_code, follower_en}),
  .vadj_code(vadj_code), .follower_en(follower_en)
);

// File: tb/lcd_i2c_cmd_slave_test.sv
module lcd_i2c_cmd_slave_test;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 8;
  localparam int DEPTH = 22;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1, sda_m = 1'b1;
  logic       sda_oe, sda_line;
  logic [4:0] disp_addr = '0;
  logic [7:0] disp_data;
  logic       bias_half, frame_fast, osc_on, disp_on, seg_on_shared, vadj_en, follower_en;
  logic [1:0] blink_sel;
  logic [3:0] vadj_code;

  int tests = 0, fails = 0;
  bit done = 0;

  logic [7:0] m_ram [DEPTH];
  logic [4:0] m_ptr;
  logic [3:0] m_mode;
  logic [1:0] m_blink;
  logic [5:0] m_vadj;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  lcd_i2c_cmd_slave uut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line), .sda_oe(sda_oe),
    .disp_addr(disp_addr), .disp_data(disp_data), .bias_half(bias_half),
    .frame_fast(frame_fast), .osc_on(osc_on), .disp_on(disp_on),
    .blink_sel(blink_sel), .seg_on_shared(seg_on_shared), .vadj_en(vadj_en),
    .vadj_code(vadj_code), .follower_en(follower_en)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [12:0] dut_cfg();
    return {frame_fast, osc_on, disp_on, bias_half, blink_sel, seg_on_shared,
            vadj_en, vadj_code, follower_en};
  endfunction

  function automatic logic [12:0] exp_cfg();
    logic fol;
    fol = !(m_vadj[3:0] == 4'h0 || m_vadj[5:4] == 2'b10);
    return {m_mode[3], m_mode[2], m_mode[2] & m_mode[1], m_mode[0], m_blink,
            m_vadj, fol};
  endfunction

  // Model of a first byte; returns 1 if later bytes are stored.
  function automatic bit model_first(input logic [7:0] b);
    if (b < 8'd22) begin m_ptr = b[4:0]; return 1; end
    if (b[7:6] == 2'b01) m_vadj = b[5:0];
    else if (b[7:5] == 3'b100 && b[1] == 1'b0) m_mode = {b[4], b[3], b[2], b[0]};
    else if (b[7:2] == 6'b110000) m_blink = b[1:0];
    return 0;
  endfunction

  task automatic i2c_start();
    sda_m = 1'b1; tick(2*Q); scl_m = 1'b1; tick(Q); sda_m = 1'b0; tick(Q); scl_m = 1'b0;
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; tick(2*Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(2*Q);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit glitch, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      tick(Q); sda_m = b[i]; tick(Q); scl_m = 1'b1; tick(Q);
      if (glitch) begin sda_m = ~b[i]; tick(1); sda_m = b[i]; tick(Q-1); end
      else tick(Q);
      scl_m = 1'b0;
    end
    tick(Q); sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
    acked = ~sda_line; tick(Q); scl_m = 1'b0;
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      tick(Q); sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
      b[i] = sda_line; tick(Q); scl_m = 1'b0;
    end
    tick(Q); sda_m = ~give_ack; tick(Q); scl_m = 1'b1; tick(2*Q); scl_m = 1'b0;
    tick(Q); sda_m = 1'b1;
  endtask

  task automatic read_disp(input int a, output logic [7:0] d);
    disp_addr = 5'(a); tick(1); d = disp_data;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic       ack;
    logic [7:0] d;
    bit         oe_seen;
    for (int i = 0; i < DEPTH; i++) m_ram[i] = 8'h00;
    m_ptr = 0; m_mode = 4'h0; m_blink = 2'b00; m_vadj = 6'b110000;
    tick(5); rst_n = 1'b1; tick(5);

    // R11 reset state
    check("R11 cfg", 32'(dut_cfg()), 32'(13'b0000_00_11_0000_0));
    check("R11 sda_oe", 32'(sda_oe), 32'd0);

    // R1 foreign address ignored
    i2c_start(); send_byte(8'h7C, 0, ack); i2c_stop();
    check("R1 foreign addr ack", 32'(ack), 32'd0);

    // R3/R2 fill the whole memory from location 0
    i2c_start(); send_byte(8'h7E, 0, ack);
    check("R1 write addr ack", 32'(ack), 32'd1);
    send_byte(8'h00, 0, ack);
    check("R2 pointer byte ack", 32'(ack), 32'd1);
    for (int i = 0; i < DEPTH; i++) begin
      send_byte(8'(i*37 + 5), 0, ack);
      m_ram[i] = 8'(i*37 + 5);
      check("R2 data ack", 32'(ack), 32'd1);
    end
    i2c_stop();
    for (int i = 0; i < DEPTH; i++) begin
      read_disp(i, d);
      check("R3 stored byte", 32'(d), 32'(m_ram[i]));
    end

    // R4 write wrap 15h -> 00h
    i2c_start(); send_byte(8'h7E, 0, ack); send_byte(8'h14, 0, ack);
    send_byte(8'hA1, 0, ack); send_byte(8'hA2, 0, ack); send_byte(8'hA3, 0, ack);
    i2c_stop();
    m_ram[20] = 8'hA1; m_ram[21] = 8'hA2; m_ram[0] = 8'hA3;
    read_disp(20, d); check("R4 wrap loc 20", 32'(d), 32'hA1);
    read_disp(21, d); check("R4 wrap loc 21", 32'(d), 32'hA2);
    read_disp(0, d);  check("R4 wrap loc 0", 32'(d), 32'hA3);

    // R5 read through the wrap, NACK on last
    i2c_start(); send_byte(8'h7E, 0, ack); send_byte(8'h13, 0, ack);
    i2c_start(); send_byte(8'h7F, 0, ack);
    check("R1 read addr ack", 32'(ack), 32'd1);
    for (int k = 0; k < 4; k++) begin
      recv_byte(k != 3, d);
      check("R5 read data", 32'(d), 32'(m_ram[(19 + k) % DEPTH]));
    end
    // R5 after NACK the slave stays silent while clocks continue
    oe_seen = 0;
    for (int k = 0; k < 9; k++) begin
      for (int t = 0; t < 4*Q; t++) begin
        scl_m = (t >= 2*Q); tick(1); oe_seen |= sda_oe;
      end
    end
    scl_m = 1'b0;
    i2c_stop();
    check("R5 silent after NACK", 32'(oe_seen), 32'd0);
    // R4 NACK did not advance: pointer is at 00h
    i2c_start(); send_byte(8'h7F, 0, ack); recv_byte(0, d); i2c_stop();
    check("R4 no advance on NACK", 32'(d), 32'(m_ram[0]));

    // R10 command first, later bytes ignored
    i2c_start(); send_byte(8'h7E, 0, ack); send_byte(8'h9C, 0, ack);
    send_byte(8'h03, 0, ack);
    check("R10 trailing byte acked", 32'(ack), 32'd1);
    send_byte(8'hC3, 0, ack); send_byte(8'h55, 0, ack); i2c_stop();
    void'(model_first(8'h9C));
    check("R6/R10 cfg", 32'(dut_cfg()), 32'(exp_cfg()));
    read_disp(0, d); check("R10 memory untouched", 32'(d), 32'(m_ram[0]));
    i2c_start(); send_byte(8'h7F, 0, ack); recv_byte(0, d); i2c_stop();
    check("R10 pointer untouched", 32'(d), 32'(m_ram[0]));

    // R12 one-clock SDA glitches while SCL high
    i2c_start(); send_byte(8'h7E, 1, ack); send_byte(8'h05, 1, ack);
    send_byte(8'h5A, 1, ack); i2c_stop();
    m_ram[5] = 8'h5A; m_ptr = 5'd6;
    read_disp(5, d); check("R12 glitch rejected", 32'(d), 32'h5A);

    // R8 follower cases
    i2c_start(); send_byte(8'h7E, 0, ack); send_byte(8'h65, 0, ack); i2c_stop();
    check("R8 de=1 ve=0 follower", 32'(follower_en), 32'd0);
    i2c_start(); send_byte(8'h7E, 0, ack); send_byte(8'h45, 0, ack); i2c_stop();
    check("R8 de=0 ve=0 follower", 32'(follower_en), 32'd1);
    void'(model_first(8'h45));

    // R6 R7 R8 R9 sweep of first-byte values
    for (int v = 0; v < 256; v += 3) begin
      i2c_start(); send_byte(8'h7E, 0, ack); send_byte(8'(v), 0, ack); i2c_stop();
      void'(model_first(8'(v)));
      check("R6/R7/R8/R9 sweep cfg", 32'(dut_cfg()), 32'(exp_cfg()));
    end

    // R9 out-of-range pointer byte is not a pointer
    i2c_start(); send_byte(8'h7E, 0, ack); send_byte(8'h02, 0, ack); i2c_stop();
    m_ptr = 5'd2;
    i2c_start(); send_byte(8'h7E, 0, ack); send_byte(8'h1F, 0, ack);
    send_byte(8'h77, 0, ack); i2c_stop();
    check("R9 cfg unchanged", 32'(dut_cfg()), 32'(exp_cfg()));
    i2c_start(); send_byte(8'h7F, 0, ack); recv_byte(0, d); i2c_stop();
    check("R9 pointer kept", 32'(d), 32'(m_ram[2]));

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule